// File: doc/BRIEF.md
# Macrocell Register Bank with Test Access

This block holds the output registers of a small programmable logic array together with the storage and access logic used to test and configure them. Each macrocell has a single flip-flop. The array feeds that flop a next-state bit. The flop's value goes back to the array as feedback, and goes out to the pin through a polarity stage that may invert it. One configuration word per macrocell sets that polarity. A separate bank of words holds a free-form user signature.

A narrow parallel test port carries one command per cycle. A command can force a chosen register high or low, write or verify a configuration word, write or read a signature word, set a one-way security lock, or erase all stored contents. Once the lock is set, forcing and configuration access are refused, but the signature stays readable. A refused command raises a one-cycle error strobe and changes nothing. After reset is released, normal register updates are held off for a configurable number of cycles, so the flops settle before they follow the array.

Top module: `mcell_regbank`

## Requirements
- R1: While reset is asserted and right after it, every register reads 0 on `q_fb`. Reset also clears configuration, signature and lock, so every `q_pin` reads 0 after reset.
- R2: For each macrocell i, `q_pin[i]` equals `q_fb[i]` XOR bit 0 of configuration word i. A 1 in that bit inverts the pin.
- R3: Opcode 1 (force) with `tp_addr`=i and `tp_wdata[0]`=v sets register i to v at that edge. The other registers are left alone.
- R4: When a force targets register i in the same cycle as an update enable, register i takes the forced value and the other registers take `d_in`.
- R5: For the first HOLDOFF clock edges after reset is released, `upd_en` is ignored. It is obeyed from edge HOLDOFF+1 onward.
- R6: Opcode 2 writes `tp_wdata` into configuration word `tp_addr`. Opcode 3 returns that word on `rd_data`, with `rd_valid` high for the cycle after the command.
- R7: Opcode 4 writes signature word `tp_addr`, which holds bits [8k+7:8k] for k=`tp_addr`. Opcode 5 reads that word back in the same way as opcode 3. Signature reads and writes are accepted while locked.
- R8: Opcode 6 sets the lock at its own edge. From the very next command on, force (1), configuration write (2) and configuration read (3) are refused.
- R9: A refused command pulses `tp_err` high for exactly the cycle after it, keeps `rd_valid` low, and leaves registers, configuration and signature unchanged.
- R10: The lock can only go from 0 to 1 and stays set through any number of cycles. Only opcode 7 (erase) clears it, and erase also clears every configuration and signature word.
- R11: A configuration or force address of NUM_REGS or more, or a signature address of SIG_BITS/DATA_W or more, is refused as in R9.
- R12: After the hold-off, `upd_en`=1 loads `d_in` into every register that is not being forced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| d_in | input | NUM_REGS | Next-state bits from the logic array |
| upd_en | input | 1 | Clock enable for normal register updates |
| tp_op | input | 3 | Test port opcode (0 none, 1 force, 2 cfg write, 3 cfg read, 4 sig write, 5 sig read, 6 secure, 7 erase) |
| tp_addr | input | ADDR_W | Register, configuration or signature word index |
| tp_wdata | input | DATA_W | Write data; bit 0 is the forced value |
| q_fb | output | NUM_REGS | Register values fed back to the array |
| q_pin | output | NUM_REGS | Register values after polarity |
| rd_data | output | DATA_W | Read data from the test port |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| tp_err | output | 1 | Previous command was refused |

## Verification
The bench uses the default build: ten registers, 8-bit words, a 64-bit signature and a hold-off of four cycles. With ten cells against eight signature words, the bench can force every register to both values and write and read back every word. The 4-bit address also reaches slots beyond both ranges, so out-of-range refusals are tested too. Because the hold-off is short, the bench can step through each ignored edge and find the first edge that is obeyed. It then covers the lock, the refusals while locked, signature access while locked, and the erase.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_PRELOAD = 3'd1,
      OP_CFG_WR  = 3'd2,
      OP_CFG_RD  = 3'd3,
      OP_SIG_WR  = 3'd4,
      OP_SIG_RD  = 3'd5,
      OP_SECURE  = 3'd6,
      OP_ERASE   = 3'd7
   } tp_op_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mcb_holdoff.sv
module mcb_holdoff #(
   parameter int HOLDOFF = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic upd_ok
);

   generate
      if (HOLDOFF == 0) begin : g_none
         assign upd_ok = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(HOLDOFF + 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (cnt_q != CW'(HOLDOFF))
               cnt_q <= cnt_q + 1'b1;
         end

         assign upd_ok = (cnt_q == CW'(HOLDOFF));

         p_holdoff_stays_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && upd_ok) |=> upd_ok);
      end
   endgenerate

endmodule

// File: rtl/mcb_cell.sv
module mcb_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   input  logic upd,
   input  logic pl_stb,
   input  logic pl_val,
   input  logic pol,
   output logic q_fb,
   output logic q_pin
);

   logic r_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         r_q <= 1'b0;
      else if (pl_stb)
         r_q <= pl_val;
      else if (upd)
         r_q <= d;
   end

   assign q_fb  = r_q;
   assign q_pin = r_q ^ pol;

   p_preload_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && pl_stb) |=> (q_fb == $past(pl_val)));

   p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !pl_stb && !upd) |=> $stable(q_fb));

endmodule

// File: rtl/mcb_access.sv
module mcb_access
   import mcb_pkg::*;
#(
   parameter int NUM_REGS = 10,
   parameter int DATA_W   = 8,
   parameter int SIG_BITS = 64,
   parameter int ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  tp_op_e              op,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NUM_REGS-1:0] pl_stb,
   output logic                pl_val,
   output logic [NUM_REGS-1:0] pol,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_valid,
   output logic                err
);

   localparam int SIG_WORDS = SIG_BITS / DATA_W;

   logic [DATA_W-1:0] cfg_q [NUM_REGS];
   logic [DATA_W-1:0] sig_q [SIG_WORDS];
   logic              lock_q;
   logic              cfg_rng, sig_rng, refuse, accept;
   logic [DATA_W-1:0] cfg_mux, sig_mux;
   logic [DATA_W-1:0] rd_q;
   logic              rdv_q, err_q;

   assign cfg_rng = (int'(addr) < NUM_REGS);
   assign sig_rng = (int'(addr) < SIG_WORDS);

   always_comb begin
      unique case (op)
         OP_PRELOAD, OP_CFG_WR, OP_CFG_RD: refuse = lock_q || !cfg_rng;
         OP_SIG_WR, OP_SIG_RD:             refuse = !sig_rng;
         default:                          refuse = 1'b0;
      endcase
   end

   assign accept = !refuse;
   assign pl_val = wdata[0];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_sel
         assign pl_stb[gi] = (op == OP_PRELOAD) && accept && (addr == ADDR_W'(gi));
         assign pol[gi]    = cfg_q[gi][0];
      end
   endgenerate

   always_comb begin
      cfg_mux = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (addr == ADDR_W'(k)) cfg_mux = cfg_q[k];
   end

   always_comb begin
      sig_mux = '0;
      for (int k = 0; k < SIG_WORDS; k++)
         if (addr == ADDR_W'(k)) sig_mux = sig_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_REGS; k++) cfg_q[k] <= '0;
         for (int k = 0; k < SIG_WORDS; k++) sig_q[k] <= '0;
         lock_q <= 1'b0;
      end else if (op == OP_ERASE) begin
         for (int k = 0; k < NUM_REGS; k++) cfg_q[k] <= '0;
         for (int k = 0; k < SIG_WORDS; k++) sig_q[k] <= '0;
         lock_q <= 1'b0;
      end else begin
         if (op == OP_SECURE)
            lock_q <= 1'b1;
         for (int k = 0; k < NUM_REGS; k++)
            if (op == OP_CFG_WR && accept && addr == ADDR_W'(k))
               cfg_q[k] <= wdata;
         for (int k = 0; k < SIG_WORDS; k++)
            if (op == OP_SIG_WR && accept && addr == ADDR_W'(k))
               sig_q[k] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         rdv_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         err_q <= refuse;
         rdv_q <= accept && (op == OP_CFG_RD || op == OP_SIG_RD);
         if (accept && op == OP_CFG_RD)
            rd_q <= cfg_mux;
         else if (accept && op == OP_SIG_RD)
            rd_q <= sig_mux;
      end
   end

   assign rd_data  = rd_q;
   assign rd_valid = rdv_q;
   assign err      = err_q;

   p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && lock_q && op != OP_ERASE) |=> lock_q);

   p_secure_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && op == OP_SECURE) |=> lock_q);

   p_locked_preload_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && lock_q && op == OP_PRELOAD) |=> (err && !rd_valid));

   p_locked_verify_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && lock_q && op == OP_CFG_RD) |=> !rd_valid);

   p_locked_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> (pl_stb == '0));

   p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(err && rd_valid));

endmodule

// File: rtl/mcell_regbank.sv
module mcell_regbank
   import mcb_pkg::*;
#(
   parameter int NUM_REGS = 10,
   parameter int DATA_W   = 8,
   parameter int SIG_BITS = 64,
   parameter int HOLDOFF  = 4,
   localparam int SIG_WORDS = SIG_BITS / DATA_W,
   localparam int ADDR_W    = $clog2(max_of(max_of(NUM_REGS, SIG_WORDS), 2))
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] d_in,
   input  logic                upd_en,
   input  logic [2:0]          tp_op,
   input  logic [ADDR_W-1:0]   tp_addr,
   input  logic [DATA_W-1:0]   tp_wdata,
   output logic [NUM_REGS-1:0] q_fb,
   output logic [NUM_REGS-1:0] q_pin,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_valid,
   output logic                tp_err
);

   generate
      if (NUM_REGS < 1) begin : g_bad_regs
         $error("NUM_REGS must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SIG_BITS < DATA_W || (SIG_BITS % DATA_W) != 0) begin : g_bad_sig
         $error("SIG_BITS must be a positive multiple of DATA_W");
      end
      if (HOLDOFF < 0) begin : g_bad_hold
         $error("HOLDOFF must not be negative");
      end
   endgenerate

   logic [NUM_REGS-1:0] pl_stb;
   logic                pl_val;
   logic [NUM_REGS-1:0] pol;
   logic                upd_ok;
   logic                upd;

   mcb_holdoff #(.HOLDOFF(HOLDOFF)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_ok (upd_ok)
   );

   assign upd = upd_en && upd_ok;

   mcb_access #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .SIG_BITS (SIG_BITS),
      .ADDR_W   (ADDR_W)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (tp_op_e'(tp_op)),
      .addr     (tp_addr),
      .wdata    (tp_wdata),
      .pl_stb   (pl_stb),
      .pl_val   (pl_val),
      .pol      (pol),
      .rd_data  (rd_data),
      .rd_valid (rd_valid),
      .err      (tp_err)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_REGS; gi++) begin : g_cell
         mcb_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .d      (d_in[gi]),
            .upd    (upd),
            .pl_stb (pl_stb[gi]),
            .pl_val (pl_val),
            .pol    (pol[gi]),
            .q_fb   (q_fb[gi]),
            .q_pin  (q_pin[gi])
         );
      end
   endgenerate

   p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pl_stb));

   p_no_update_in_holdoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !upd_ok && pl_stb == '0) |=> $stable(q_fb));

endmodule

// File: tb/mcell_regbank_tb_top.sv
module mcell_regbank_tb_top;

   localparam int NR  = 10;
   localparam int DW  = 8;
   localparam int SB  = 64;
   localparam int HO  = 4;
   localparam int SW  = SB / DW;
   localparam int AW  = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NR-1:0] d_in;
   logic          upd_en;
   logic [2:0]    tp_op;
   logic [AW-1:0] tp_addr;
   logic [DW-1:0] tp_wdata;
   logic [NR-1:0] q_fb, q_pin;
   logic [DW-1:0] rd_data;
   logic          rd_valid, tp_err;

   int n_vec = 0;
   int n_bad = 0;

   logic [NR-1:0] exp_fb;
   logic [NR-1:0] exp_pol;

   always #4 clk = ~clk;

   mcell_regbank #(.NUM_REGS(NR), .DATA_W(DW), .SIG_BITS(SB), .HOLDOFF(HO)) dut_i (
      .clk(clk), .rst_n(rst_n), .d_in(d_in), .upd_en(upd_en),
      .tp_op(tp_op), .tp_addr(tp_addr), .tp_wdata(tp_wdata),
      .q_fb(q_fb), .q_pin(q_pin), .rd_data(rd_data),
      .rd_valid(rd_valid), .tp_err(tp_err)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tp(input logic [2:0] op, input int a, input logic [DW-1:0] wd);
      tp_op    = op;
      tp_addr  = AW'(a);
      tp_wdata = wd;
      @(negedge clk);
      tp_op    = 3'd0;
   endtask

   function automatic logic [DW-1:0] cfg_word(input int i);
      return DW'((i << 4) | (i & 1));
   endfunction

   function automatic logic [DW-1:0] sig_word(input int k);
      return DW'((8'hA5 ^ (k * 37)) & 8'hFF);
   endfunction

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 50000);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; upd_en = 1'b1; d_in = '1;
      tp_op = 3'd0; tp_addr = '0; tp_wdata = '0;
      repeat (3) @(negedge clk);
      chk("R1 fb in reset", 64'(q_fb), 64'(0));
      chk("R1 pin in reset", 64'(q_pin), 64'(0));
      rst_n = 1'b1;

      // R5 / R12: edges 1..HO ignored, HO+1 obeyed
      for (int k = 1; k <= HO + 2; k++) begin
         @(negedge clk);
         chk($sformatf("R5 holdoff edge %0d", k), 64'(q_fb),
             (k > HO) ? 64'({NR{1'b1}}) : 64'(0));
      end
      upd_en = 1'b0;
      exp_fb = '1;

      // R6 / R2: configuration write, verify, polarity
      exp_pol = '0;
      for (int i = 0; i < NR; i++) begin
         tp(3'd2, i, cfg_word(i));
         exp_pol[i] = cfg_word(i)[0];
      end
      for (int i = 0; i < NR; i++) begin
         tp(3'd3, i, '0);
         chk($sformatf("R6 cfg valid %0d", i), 64'(rd_valid), 64'(1));
         chk($sformatf("R6 cfg read %0d", i), 64'(rd_data), 64'(cfg_word(i)));
      end
      chk("R2 pin polarity", 64'(q_pin), 64'(exp_fb ^ exp_pol));

      // R3: each register forced to both values
      for (int i = 0; i < NR; i++) begin
         for (int v = 0; v < 2; v++) begin
            tp(3'd1, i, DW'(v));
            exp_fb[i] = v[0];
            chk($sformatf("R3 preload reg %0d to %0d", i, v), 64'(q_fb), 64'(exp_fb));
            chk($sformatf("R2 pin reg %0d", i), 64'(q_pin), 64'(exp_fb ^ exp_pol));
         end
      end

      // R4: force beats update on the same edge
      d_in = '0; upd_en = 1'b1;
      tp(3'd1, 3, 8'h01);
      upd_en = 1'b0;
      exp_fb = NR'(1 << 3);
      chk("R4 preload over update", 64'(q_fb), 64'(exp_fb));

      // R12: plain update
      d_in = NR'(10'h2A5); upd_en = 1'b1;
      @(negedge clk);
      upd_en = 1'b0;
      exp_fb = NR'(10'h2A5);
      chk("R12 update loads d_in", 64'(q_fb), 64'(exp_fb));

      // R7: signature write and read
      for (int k = 0; k < SW; k++) tp(3'd4, k, sig_word(k));
      for (int k = 0; k < SW; k++) begin
         tp(3'd5, k, '0);
         chk($sformatf("R7 sig read %0d", k), 64'(rd_data), 64'(sig_word(k)));
      end

      // R11: out-of-range addresses
      tp(3'd1, 12, 8'h00);
      chk("R11 preload range err", 64'(tp_err), 64'(1));
      chk("R11 preload range fb", 64'(q_fb), 64'(exp_fb));
      tp(3'd5, 9, '0);
      chk("R11 sig range err", 64'(tp_err), 64'(1));
      chk("R11 sig range valid", 64'(rd_valid), 64'(0));
      tp(3'd3, 10, '0);
      chk("R11 cfg range err", 64'(tp_err), 64'(1));
      @(negedge clk);
      chk("R9 err one cycle", 64'(tp_err), 64'(0));

      // R8 / R9: lock takes effect at once
      tp(3'd6, 0, '0);
      chk("R8 secure no err", 64'(tp_err), 64'(0));
      tp(3'd1, 0, 8'h01);
      chk("R8 locked preload err", 64'(tp_err), 64'(1));
      chk("R9 locked preload fb", 64'(q_fb), 64'(exp_fb));
      @(negedge clk);
      chk("R9 err cleared", 64'(tp_err), 64'(0));
      tp(3'd3, 1, '0);
      chk("R8 locked verify err", 64'(tp_err), 64'(1));
      chk("R8 locked verify valid", 64'(rd_valid), 64'(0));
      tp(3'd2, 0, 8'h01);
      chk("R9 locked cfg write err", 64'(tp_err), 64'(1));
      chk("R9 locked cfg write pin", 64'(q_pin), 64'(exp_fb ^ exp_pol));
      for (int k = 0; k < SW; k++) begin
         tp(3'd5, k, '0);
         chk($sformatf("R7 locked sig read %0d", k), 64'(rd_data), 64'(sig_word(k)));
         chk($sformatf("R7 locked sig valid %0d", k), 64'(rd_valid), 64'(1));
      end

      // R10: lock stays until erase
      repeat (5) @(negedge clk);
      tp(3'd1, 5, 8'h00);
      chk("R10 lock persists", 64'(tp_err), 64'(1));
      chk("R10 lock persists fb", 64'(q_fb), 64'(exp_fb));
      tp(3'd7, 0, '0);
      tp(3'd3, 1, '0);
      chk("R10 erase cfg valid", 64'(rd_valid), 64'(1));
      chk("R10 erase cfg cleared", 64'(rd_data), 64'(0));
      tp(3'd5, 2, '0);
      chk("R10 erase sig cleared", 64'(rd_data), 64'(0));
      chk("R10 erase pin follows fb", 64'(q_pin), 64'(exp_fb));
      tp(3'd1, 5, 8'h00);
      exp_fb[5] = 1'b0;
      chk("R10 preload after erase", 64'(q_fb), 64'(exp_fb));

      // R1: reset again mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 fb after second reset", 64'(q_fb), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

endmodule